// File: doc/BRIEF.md
# Bit-Serial Vector Add Sequencer

This block drives an array of one-bit processing units that sit beside the rows of a shared memory. Each unit has three one-bit registers: RA and RB hold operands and RC holds the carry. The memory side has a column port that moves one bit-slice, one bit from every row, per access. After a start pulse the sequencer issues one instruction per cycle. Each instruction gives a column address, a read or write strobe, a register select and an operation code. Together these instructions add two m-bit vectors held in column groups A and B and place the (m+1)-bit sum in column group S. Every row is processed in parallel, so the run length depends only on m.

Each bit takes three cycles: read B into RB, add, then write the sum from RB. The add cycle also reads the next A bit into RA. After the last bit the carry in RC is written to the top column of S. A one-cycle done pulse follows. The base columns and the width are captured at start.

Top module: `bitser_add_seq`

## Requirements
- R1: After reset, and whenever idle, the block issues no strobe. It drives op NOP (2'b00), register select 2'b00, address 0 and done low.
- R2: A start accepted in idle gives, in the next cycle, a read of column A base into RA (select 2'b00) together with op CLR_C (2'b01), which clears RC.
- R3: For bit i, the block first reads column B base+i into RB (select 2'b01). Two cycles later it writes RB to column S base+i (select 2'b01, write strobe).
- R4: Between those two cycles, an add cycle issues op ADD (2'b10). For i < m−1 this cycle also reads column A base+i+1 into RA. For the last bit it issues no strobe and address 0.
- R5: The cycle after the write of bit m−1, RC (select 2'b10) is written to column S base+m.
- R6: Done is high for exactly one cycle, 3m+3 cycles after the clock edge that accepts start. The block is idle afterwards.
- R7: A start seen while a run is in progress is ignored, and the run continues unchanged.
- R8: A start with width 0 or above 16 is ignored, and the block stays idle.
- R9: Read and write strobes are never high in the same cycle.
- R10: Column addresses wrap modulo 2^COL_W.
- R11: Changes to the base or width inputs during a run do not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled in idle |
| a_base | input | COL_W | First column of operand A |
| b_base | input | COL_W | First column of operand B |
| s_base | input | COL_W | First column of result S |
| width | input | clog2(MAX_W+1) | Operand width m |
| col_addr | output | COL_W | Column address of this cycle's access |
| col_rd | output | 1 | Read the column into the selected register of every unit |
| col_wr | output | 1 | Write the selected register of every unit into the column |
| reg_sel | output | 2 | Register select: 00 RA, 01 RB, 10 RC |
| op | output | 2 | Unit operation: 00 NOP, 01 clear RC, 10 add |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench compares the full instruction word in every cycle of a run against a schedule derived from m and the bases. A wrong state or bit index therefore shows up at the ports within one cycle: as a misplaced strobe, a wrong register select, or an address off by one. A corrupted latched width or base shows up at the first address that uses it. A missed transition shows up as a done pulse that is early, late or repeated.

// File: rtl/bitser_add_pkg.sv
package bitser_add_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LDA,
      ST_RDB,
      ST_ADD,
      ST_WRS,
      ST_WRC,
      ST_FIN
   } seq_state_t;

   localparam logic [1:0] SEL_RA  = 2'b00;
   localparam logic [1:0] SEL_RB  = 2'b01;
   localparam logic [1:0] SEL_RC  = 2'b10;

   localparam logic [1:0] OP_NOP  = 2'b00;
   localparam logic [1:0] OP_CLRC = 2'b01;
   localparam logic [1:0] OP_ADD  = 2'b10;
endpackage

// File: rtl/bitser_add_fsm.sv
module bitser_add_fsm
   import bitser_add_pkg::*;
#(
   parameter int MAX_W = 16,
   parameter int CNT_W = $clog2(MAX_W),
   parameter int WID_W = $clog2(MAX_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WID_W-1:0] width,
   output seq_state_t       state,
   output logic [CNT_W-1:0] bit_idx,
   output logic [WID_W-1:0] width_q,
   output logic             last_bit,
   output logic             launch
);
   logic width_ok;

   assign width_ok = (width != '0) && (width <= WID_W'(MAX_W));
   assign launch   = (state == ST_IDLE) && start && width_ok;
   assign last_bit = (WID_W'(bit_idx) == width_q - WID_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_idx <= '0;
         width_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (launch) begin
               state   <= ST_LDA;
               width_q <= width;
               bit_idx <= '0;
            end
            ST_LDA: state <= ST_RDB;
            ST_RDB: state <= ST_ADD;
            ST_ADD: state <= ST_WRS;
            ST_WRS: if (last_bit) begin
               state <= ST_WRC;
            end else begin
               state   <= ST_RDB;
               bit_idx <= bit_idx + 1'b1;
            end
            ST_WRC: state <= ST_FIN;
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start && width_ok) |=> (state == ST_LDA));
   p_bad_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start && !width_ok) |=> (state == ST_IDLE));
   p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> (state != ST_LDA));
   p_bit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WRS && !last_bit) |=> (bit_idx == $past(bit_idx) + 1'b1));
   p_width_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> $stable(width_q));
endmodule

// File: rtl/bitser_add_agen.sv
module bitser_add_agen
   import bitser_add_pkg::*;
#(
   parameter int COL_W = 8,
   parameter int CNT_W = 4,
   parameter int WID_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic [COL_W-1:0] a_base,
   input  logic [COL_W-1:0] b_base,
   input  logic [COL_W-1:0] s_base,
   input  seq_state_t       state,
   input  logic [CNT_W-1:0] bit_idx,
   input  logic [WID_W-1:0] width_q,
   input  logic             last_bit,
   output logic [COL_W-1:0] col_addr
);
   logic [COL_W-1:0] a_q, b_q, s_q;
   logic [COL_W-1:0] base, offs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         s_q <= '0;
      end else if (launch) begin
         a_q <= a_base;
         b_q <= b_base;
         s_q <= s_base;
      end
   end

   always_comb begin
      base = '0;
      offs = '0;
      unique case (state)
         ST_LDA: base = a_q;
         ST_RDB: begin base = b_q; offs = COL_W'(bit_idx); end
         ST_ADD: if (!last_bit) begin
            base = a_q;
            offs = COL_W'(bit_idx) + COL_W'(1);
         end
         ST_WRS: begin base = s_q; offs = COL_W'(bit_idx); end
         ST_WRC: begin base = s_q; offs = COL_W'(width_q); end
         default: ;
      endcase
      col_addr = base + offs;
   end

   p_base_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> ($stable(a_q) && $stable(b_q) && $stable(s_q)));
endmodule

// File: rtl/bitser_add_issue.sv
module bitser_add_issue
   import bitser_add_pkg::*;
(
   input  seq_state_t state,
   input  logic       last_bit,
   output logic       rd,
   output logic       wr,
   output logic [1:0] sel,
   output logic [1:0] op,
   output logic       fin
);
   always_comb begin
      rd  = 1'b0;
      wr  = 1'b0;
      sel = SEL_RA;
      op  = OP_NOP;
      fin = 1'b0;
      unique case (state)
         ST_LDA: begin rd = 1'b1; op = OP_CLRC; end
         ST_RDB: begin rd = 1'b1; sel = SEL_RB; end
         ST_ADD: begin op = OP_ADD; rd = !last_bit; end
         ST_WRS: begin wr = 1'b1; sel = SEL_RB; end
         ST_WRC: begin wr = 1'b1; sel = SEL_RC; end
         ST_FIN: fin = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/bitser_add_seq.sv
module bitser_add_seq
   import bitser_add_pkg::*;
#(
   parameter int COL_W   = 8,
   parameter int MAX_W   = 16,
   parameter bit REG_OUT = 1'b0,
   localparam int CNT_W  = $clog2(MAX_W),
   localparam int WID_W  = $clog2(MAX_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COL_W-1:0] a_base,
   input  logic [COL_W-1:0] b_base,
   input  logic [COL_W-1:0] s_base,
   input  logic [WID_W-1:0] width,
   output logic [COL_W-1:0] col_addr,
   output logic             col_rd,
   output logic             col_wr,
   output logic [1:0]       reg_sel,
   output logic [1:0]       op,
   output logic             done
);
   generate
      if (MAX_W < 2) begin : g_bad_maxw
         $error("MAX_W must be at least 2");
      end
      if (COL_W < WID_W) begin : g_bad_colw
         $error("COL_W must hold the width value");
      end
   endgenerate

   seq_state_t       state;
   logic [CNT_W-1:0] bit_idx;
   logic [WID_W-1:0] width_q;
   logic             last_bit, launch;
   logic [COL_W-1:0] addr_c;
   logic             rd_c, wr_c, fin_c;
   logic [1:0]       sel_c, op_c;

   bitser_add_fsm #(.MAX_W(MAX_W), .CNT_W(CNT_W), .WID_W(WID_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .width(width),
      .state(state), .bit_idx(bit_idx), .width_q(width_q),
      .last_bit(last_bit), .launch(launch)
   );

   bitser_add_agen #(.COL_W(COL_W), .CNT_W(CNT_W), .WID_W(WID_W)) u_agen (
      .clk(clk), .rst_n(rst_n), .launch(launch),
      .a_base(a_base), .b_base(b_base), .s_base(s_base),
      .state(state), .bit_idx(bit_idx), .width_q(width_q),
      .last_bit(last_bit), .col_addr(addr_c)
   );

   bitser_add_issue u_issue (
      .state(state), .last_bit(last_bit),
      .rd(rd_c), .wr(wr_c), .sel(sel_c), .op(op_c), .fin(fin_c)
   );

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               col_addr <= '0;
               col_rd   <= 1'b0;
               col_wr   <= 1'b0;
               reg_sel  <= SEL_RA;
               op       <= OP_NOP;
               done     <= 1'b0;
            end else begin
               col_addr <= addr_c;
               col_rd   <= rd_c;
               col_wr   <= wr_c;
               reg_sel  <= sel_c;
               op       <= op_c;
               done     <= fin_c;
            end
         end
      end else begin : g_comb_out
         assign col_addr = addr_c;
         assign col_rd   = rd_c;
         assign col_wr   = wr_c;
         assign reg_sel  = sel_c;
         assign op       = op_c;
         assign done     = fin_c;
      end
   endgenerate

   p_rw_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(col_rd && col_wr));
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_carry_then_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (col_wr && reg_sel == SEL_RC) |=> done);
   p_clear_with_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CLRC) |-> (col_rd && reg_sel == SEL_RA));
   p_add_after_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ADD) |-> ($past(col_rd) && $past(reg_sel) == SEL_RB));
endmodule

// File: tb/bitser_add_seq_tb.sv
`timescale 1ns/1ps
module bitser_add_seq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] a_base = '0, b_base = '0, s_base = '0;
   logic [4:0] width = '0;
   logic [7:0] col_addr;
   logic       col_rd, col_wr, done;
   logic [1:0] reg_sel, op;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   bitser_add_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .a_base(a_base), .b_base(b_base), .s_base(s_base), .width(width),
      .col_addr(col_addr), .col_rd(col_rd), .col_wr(col_wr),
      .reg_sel(reg_sel), .op(op), .done(done)
   );

   // packed word: rd, wr, sel[1:0], op[1:0], addr[7:0], done
   function automatic logic [14:0] pack_w(logic rd, logic wr, logic [1:0] sel,
                                          logic [1:0] o, logic [7:0] ad, logic dn);
      return {rd, wr, sel, o, ad, dn};
   endfunction

   function automatic logic [14:0] exp_at(int k, logic [7:0] a, logic [7:0] b,
                                          logic [7:0] s, int m);
      int j, i, ph;
      if (k == 1) return pack_w(1, 0, 2'b00, 2'b01, a, 0);
      if (k >= 2 && k <= 3*m + 1) begin
         j = k - 2; i = j / 3; ph = j % 3;
         if (ph == 0) return pack_w(1, 0, 2'b01, 2'b00, 8'(b + i), 0);
         if (ph == 1) begin
            if (i < m - 1) return pack_w(1, 0, 2'b00, 2'b10, 8'(a + i + 1), 0);
            return pack_w(0, 0, 2'b00, 2'b10, 8'h00, 0);
         end
         return pack_w(0, 1, 2'b01, 2'b00, 8'(s + i), 0);
      end
      if (k == 3*m + 2) return pack_w(0, 1, 2'b10, 2'b00, 8'(s + m), 0);
      if (k == 3*m + 3) return pack_w(0, 0, 2'b00, 2'b00, 8'h00, 1);
      return '0;
   endfunction

   function automatic string phase_tag(int k, int m);
      if (k == 1) return "R2";
      if (k <= 3*m + 1) return (((k - 2) % 3) == 1) ? "R4" : "R3";
      if (k == 3*m + 2) return "R5";
      return "R6";
   endfunction

   task automatic check_word(string tag, int k, logic [14:0] expv);
      logic [14:0] got;
      got = pack_w(col_rd, col_wr, reg_sel, op, col_addr, done);
      n_chk++;
      if (got !== expv) begin
         n_fail++;
         $display("FAIL %s cycle %0d: got %h expected %h", tag, k, got, expv);
      end
      n_chk++;
      if (col_rd && col_wr) begin
         n_fail++;
         $display("FAIL R9 cycle %0d: got rd=1 wr=1 expected exclusive", k);
      end
   endtask

   // R2..R7, R10, R11: full run compared cycle by cycle
   task automatic run_add(string tag, logic [7:0] a, logic [7:0] b,
                          logic [7:0] s, int m, bit disturb);
      @(negedge clk);
      a_base = a; b_base = b; s_base = s; width = 5'(m); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k <= 3*m + 5; k++) begin
         if (k > 1) @(negedge clk);
         check_word({tag, "/", phase_tag(k, m)}, k, exp_at(k, a, b, s, m));
         if (disturb && k == 4) begin
            start = 1'b1; a_base = 8'h77; b_base = 8'h88;
            s_base = 8'h99; width = 5'd3;
         end
         if (disturb && k == 5) start = 1'b0;
      end
   endtask

   // R1
   task automatic t_reset();
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check_word("R1", k, '0);
      end
   endtask

   // R8: out-of-range width leaves the block idle
   task automatic t_bad_width(logic [4:0] w);
      @(negedge clk);
      a_base = 8'h05; b_base = 8'h06; s_base = 8'h07; width = w; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k <= 4; k++) begin
         if (k > 1) @(negedge clk);
         check_word("R8", k, '0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got no finish expected end of run");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      run_add("R6_m1",   8'd10,  8'd20,  8'd30, 1,  1'b0);
      run_add("R3_m4",   8'd0,   8'd4,   8'd8,  4,  1'b0);
      run_add("R6_m16",  8'd16,  8'd32,  8'd48, 16, 1'b0);
      run_add("R10_wrap",8'd250, 8'd252, 8'd254, 8, 1'b0);
      run_add("R7_R11",  8'd40,  8'd50,  8'd60, 5,  1'b1);
      t_bad_width(5'd0);
      t_bad_width(5'd17);
      run_add("R8_after",8'd1,   8'd3,   8'd5,  2,  1'b0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule